// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block judges whether a phase-locked loop has settled. Once per phase-detector cycle a strobe arrives with an unsigned phase-error magnitude, counted in a fixed time unit (1 ns per LSB by default). The block counts back-to-back strobes whose error is small. When that run is long enough it raises an active-high lock flag.

Acquiring lock and losing it use two different thresholds, which gives hysteresis. Lock is acquired below 15 units. Once held, lock is lost only when a strobe reports more than 25 units. A mode input selects whether acquisition needs a run of three or of five good strobes. Cycles without a strobe change nothing, so the decision follows the phase-detector rate and not the system clock.

Top module: `pll_lock_detect`

## Requirements
- R1: `lock_o` is active high. It rises only on the clock edge that captures a strobe whose error is below `ACQ_TH` (default 15).
- R2: With `need_five` = 0, `lock_o` goes high in the cycle after the edge that captures the third consecutive strobe with error below `ACQ_TH`.
- R3: With `need_five` = 1, `lock_o` goes high in the cycle after the edge that captures the fifth consecutive strobe with error below `ACQ_TH`.
- R4: While locked, a strobe with error greater than `LOSE_TH` (default 25) drives `lock_o` low in the following cycle.
- R5: Clock cycles with `pd_strobe` low leave `lock_o` and the good-run count unchanged. Idle cycles between good strobes therefore do not break a run.
- R6: While locked, a strobe with error at or below `LOSE_TH` keeps `lock_o` high. This includes errors from `ACQ_TH` through `LOSE_TH`.
- R7: While unlocked, a strobe with error of `ACQ_TH` or more resets the good-run count to zero.
- R8: After lock is lost, a full run of 3 or 5 good strobes is needed to lock again.
- R9: A clock edge with `rst_n` low clears `lock_o` and the good-run count.
- R10: `need_five` is read at each strobe. A change made between strobes applies at the next strobe, against the run already counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_strobe | input | 1 | One-cycle pulse per phase-detector cycle |
| phase_err | input | ERR_W | Phase-error magnitude in time units, valid with the strobe |
| need_five | input | 1 | 0: three good strobes to lock; 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The assertions assume that `phase_err` and `need_five` are stable and meaningful whenever `pd_strobe` is high. They also assume that `ACQ_TH` is not above `LOSE_TH`. Without those assumptions, the hold and release properties would say nothing useful. The stimulus changes inputs only 1 ns after a rising edge. It raises the strobe for exactly one cycle per phase-detector event and flips the mode only on cycles without a strobe. Error values sit just at and around both thresholds (14, 15, 25, 26).

// File: rtl/ldet_pkg.sv
// Shared types for the PLL lock detector.
package ldet_pkg;
    // Band a phase-error sample falls into, relative to the two thresholds.
    typedef enum logic [1:0] {
        BAND_SMALL = 2'd0,   // below acquire threshold
        BAND_MID   = 2'd1,   // acquire threshold .. release threshold
        BAND_LARGE = 2'd2    // above release threshold
    } err_band_t;
endpackage

// File: rtl/ldet_classify.sv
// Sorts one phase-error sample into a hysteresis band.
// Assumes ACQ_TH <= LOSE_TH and both fit in ERR_W bits.
module ldet_classify
    import ldet_pkg::*;
#(
    parameter int ERR_W   = 8,
    parameter int ACQ_TH  = 15,
    parameter int LOSE_TH = 25
) (
    input  logic [ERR_W-1:0] phase_err,
    output err_band_t        band
);
    localparam logic [ERR_W-1:0] ACQ_V  = ERR_W'(ACQ_TH);
    localparam logic [ERR_W-1:0] LOSE_V = ERR_W'(LOSE_TH);

    // Purpose: compare the sample against both thresholds.
    always_comb begin
        if (phase_err < ACQ_V)       band = BAND_SMALL;
        else if (phase_err > LOSE_V) band = BAND_LARGE;
        else                         band = BAND_MID;
    end
endmodule

// File: rtl/ldet_run_counter.sv
// Counts consecutive good strobes and reports when the run is long enough.
// Assumes `advance` and `clear` are never high together.
module ldet_run_counter #(
    parameter int COUNT_LO = 3,
    parameter int COUNT_HI = 5,
    localparam int CNT_W   = $clog2(COUNT_HI + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic clear,
    input  logic need_five,
    output logic reached
);
    localparam logic [CNT_W:0] TGT_LO = (CNT_W+1)'(COUNT_LO);
    localparam logic [CNT_W:0] TGT_HI = (CNT_W+1)'(COUNT_HI);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   next_len;
    logic [CNT_W:0]   target;

    // Purpose: length of the run if this strobe is good, and the target length for the current mode.
    always_comb begin
        next_len = {1'b0, count_q} + 1'b1;
        target   = need_five ? TGT_HI : TGT_LO;
        reached  = advance && (next_len >= target);
    end

    // Purpose: hold the run length; it restarts when the run fails or completes.
    always_ff @(posedge clk) begin
        if (!rst_n)           count_q <= '0;
        else if (clear)       count_q <= '0;
        else if (advance)     count_q <= reached ? '0 : next_len[CNT_W-1:0];
    end
endmodule

// File: rtl/ldet_state.sv
// Lock flag register with hysteresis control of the run counter.
// Assumes `band` and `reached` are valid in cycles where `strobe` is high.
module ldet_state
    import ldet_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe,
    input  err_band_t band,
    input  logic      reached,
    output logic      run_adv,
    output logic      run_clr,
    output logic      locked
);
    // Purpose: steer the run counter; it only counts while unlocked.
    always_comb begin
        run_adv = strobe && !locked && (band == BAND_SMALL);
        run_clr = strobe && (locked ? (band == BAND_LARGE) : (band != BAND_SMALL));
    end

    // Purpose: set the flag on a completed run, clear it on a large error.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       locked <= 1'b0;
        else if (!locked && run_adv && reached)           locked <= 1'b1;
        else if (locked && strobe && band == BAND_LARGE)  locked <= 1'b0;
    end
endmodule

// File: rtl/pll_lock_detect.sv
// Top of the PLL lock detector: classifier, run counter and lock state.
// Assumes one pd_strobe pulse per phase-detector cycle, with phase_err valid alongside it.
module pll_lock_detect
    import ldet_pkg::*;
#(
    parameter int ERR_W    = 8,
    parameter int ACQ_TH   = 15,
    parameter int LOSE_TH  = 25,
    parameter int COUNT_LO = 3,
    parameter int COUNT_HI = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_strobe,
    input  logic [ERR_W-1:0] phase_err,
    input  logic             need_five,
    output logic             lock_o
);
    err_band_t band;
    logic      reached;
    logic      run_adv;
    logic      run_clr;

    ldet_classify #(.ERR_W(ERR_W), .ACQ_TH(ACQ_TH), .LOSE_TH(LOSE_TH)) u_class (
        .phase_err (phase_err),
        .band      (band)
    );

    ldet_run_counter #(.COUNT_LO(COUNT_LO), .COUNT_HI(COUNT_HI)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (run_adv),
        .clear     (run_clr),
        .need_five (need_five),
        .reached   (reached)
    );

    ldet_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (pd_strobe),
        .band    (band),
        .reached (reached),
        .run_adv (run_adv),
        .run_clr (run_clr),
        .locked  (lock_o)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
// Assertion checker for pll_lock_detect, attached by bind.
// Assumes phase_err is meaningful whenever pd_strobe is high.
module pll_lock_detect_chk #(
    parameter int ERR_W   = 8,
    parameter int ACQ_TH  = 15,
    parameter int LOSE_TH = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_strobe,
    input logic [ERR_W-1:0] phase_err,
    input logic             lock_o
);
    localparam logic [ERR_W-1:0] ACQ_V  = ERR_W'(ACQ_TH);
    localparam logic [ERR_W-1:0] LOSE_V = ERR_W'(LOSE_TH);

    AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(pd_strobe) && $past(phase_err) < ACQ_V)); // R1
    AST_DROP_ON_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && pd_strobe && phase_err > LOSE_V) |=> !lock_o); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_strobe |=> $stable(lock_o)); // R5
    AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && pd_strobe && phase_err <= LOSE_V) |=> lock_o); // R6
    AST_BAD_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && pd_strobe && phase_err >= ACQ_V) |=> !lock_o); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !lock_o); // R9
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .ERR_W(ERR_W), .ACQ_TH(ACQ_TH), .LOSE_TH(LOSE_TH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_strobe(pd_strobe),
    .phase_err(phase_err), .lock_o(lock_o)
);

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_strobe = 1'b0;
    logic [7:0] phase_err = '0;
    logic       need_five = 1'b0;
    logic       lock_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    string phase_tag = "R9";

    // Behavioural reference: run length and lock flag as integers.
    int  m_run = 0;
    bit  m_lock = 0;

    always #2.5 clk = ~clk;

    pll_lock_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pd_strobe(pd_strobe),
        .phase_err(phase_err), .need_five(need_five), .lock_o(lock_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lock_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update at each rising edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_run = 0;
        end else if (pd_strobe) begin
            if (m_lock) begin
                if (phase_err > 25) begin m_lock = 0; m_run = 0; end
            end else if (phase_err < 15) begin
                m_run = m_run + 1;
                if (m_run >= (need_five ? 5 : 3)) begin m_lock = 1; m_run = 0; end
            end else begin
                m_run = 0;
            end
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) if (!done) chk(phase_tag, lock_o, m_lock);

    task automatic strobe(input int err);
        @(posedge clk); #1; pd_strobe = 1'b1; phase_err = 8'(err);
        @(posedge clk); #1; pd_strobe = 1'b0; phase_err = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic lose();
        strobe(200);
        chk("R4", lock_o, 1'b0);
    endtask

    initial begin
        idle(3);
        chk("R9", lock_o, 1'b0);
        rst_n = 1'b1;
        idle(1);

        phase_tag = "R2";
        strobe(3); strobe(14);
        chk("R2", lock_o, 1'b0);
        strobe(0);
        chk("R2", lock_o, 1'b1);

        phase_tag = "R6";
        strobe(15); strobe(20); strobe(25);
        chk("R6", lock_o, 1'b1);
        phase_tag = "R5";
        idle(4);
        chk("R5", lock_o, 1'b1);
        phase_tag = "R4";
        strobe(26);
        chk("R4", lock_o, 1'b0);

        phase_tag = "R8";
        strobe(1); strobe(2);
        chk("R8", lock_o, 1'b0);
        strobe(3);
        chk("R8", lock_o, 1'b1);
        lose();

        phase_tag = "R7";
        strobe(1); strobe(1); strobe(15); strobe(1); strobe(1);
        chk("R7", lock_o, 1'b0);
        strobe(1);
        chk("R7", lock_o, 1'b1);
        lose();

        phase_tag = "R3";
        need_five = 1'b1;
        strobe(0); strobe(5); strobe(10); strobe(14);
        chk("R3", lock_o, 1'b0);
        strobe(14);
        chk("R3", lock_o, 1'b1);
        lose();

        phase_tag = "R5";
        need_five = 1'b0;
        strobe(2); idle(5); strobe(2); idle(2); strobe(2);
        chk("R5", lock_o, 1'b1);
        lose();

        phase_tag = "R10";
        need_five = 1'b1;
        strobe(1); strobe(1); strobe(1);
        chk("R10", lock_o, 1'b0);
        idle(1); need_five = 1'b0; idle(1);
        chk("R10", lock_o, 1'b0);
        strobe(1);
        chk("R10", lock_o, 1'b1);
        lose();

        phase_tag = "R9";
        strobe(1); strobe(1);
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        chk("R9", lock_o, 1'b0);
        strobe(1); strobe(1);
        chk("R9", lock_o, 1'b0);
        strobe(1);
        chk("R1", lock_o, 1'b1);

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: lock_o=%0b expected test completion", lock_o);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule